// File: doc/BRIEF.md
# Dual-Half General Purpose Timer

This block is a register-controlled timer built from two 16-bit halves that are joined into one 32-bit counter. A configuration register picks how the joined counter behaves: a 32-bit down-counter that steps on a system clock enable, or a 32-bit seconds counter that steps on a once-per-second tick input and compares against a 32-bit match value. A single level interrupt reports the masked status bits, and a one-cycle trigger pulse can be routed to an ADC on each down-counter timeout.

Software reaches the block through a simple word-addressed write/read port. Reads are combinational from the address. Software is expected to disable the timer before it changes the configuration. The prescale registers are plain storage and have no effect in either 32-bit mode.

Top module: `dual_half_timer`

## Requirements
- R1: After reset every register reads 0, the counter (address 14) reads 0, and irq and trig are low.
- R2: With configuration (address 0) at 0, a write to control (address 3) that turns bit 0 from 0 to 1 loads the counter with the half-B load value shifted left by 16 ORed with the half-A load value.
- R3: While running in configuration 0 with mode A (address 1) bit 0 clear, the counter decrements on each cycle with tick_en high; on the step from 1 to 0 it reloads in that same cycle and sets raw status (address 5) bit 0.
- R4: With mode A bit 0 set, the first timeout sets raw bit 0, leaves the counter at 0 and stops the timer.
- R5: trig is high for the single cycle after a configuration-0 timeout if control bit 5 is set, and never otherwise.
- R6: Writing the interrupt mask (address 4) keeps only the bits in 0x77; masked status (address 6) reads raw AND mask, and irq is high exactly when that value is nonzero, so raw bit 3 can never raise irq.
- R7: Writing a 1 to a bit of the clear register (address 7) clears that raw status bit.
- R8: A write to load A (address 8) or match A (address 10) stores the low 16 bits in half A and, only while configuration is below 4, the upper 16 bits in half B; their readback carries half B in the upper 16 bits only while configuration is below 4. Addresses 9 and 11 access half B in their low 16 bits.
- R9: With configuration 1, turning control bit 0 on clears the counter; each sec_tick cycle adds one, and raw bit 3 is set when the new value equals the 32-bit match (half B high, half A low); without sec_tick the count holds.
- R10: Prescale A and B (addresses 12 and 13) store and return the low 8 bits of a write and do not change countdown timing.
- R11: A control write that turns bit 0 from 1 to 0 stops the counter, which holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register word address |
| wdata | input | 2*HW | Write data |
| rdata | output | 2*HW | Read data for addr |
| tick_en | input | 1 | Countdown step enable |
| sec_tick | input | 1 | One-second step for the seconds counter |
| irq | output | 1 | Level interrupt |
| trig | output | 1 | One-cycle ADC trigger |

## Verification
The bench builds the block with its defaults, 16-bit halves and a 4-bit address. With those widths a load of 0x00010002 proves the joining of halves through the counter readback without waiting out 65 thousand cycles, while loads of 3 to 5 put periodic, one-shot and trigger-disabled timeouts within a few tens of cycles, where a queue of expected trigger cycles can be matched edge for edge. Configuration 4 reaches the narrow load and match readback rule, and three seconds ticks reach the match compare.

// File: rtl/dual_half_timer.sv
module dual_half_timer #(
  parameter int HW = 16,
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [2*HW-1:0] wdata,
  output logic [2*HW-1:0] rdata,
  input  logic            tick_en,
  input  logic            sec_tick,
  output logic            irq,
  output logic            trig
);
  localparam int DW = 2 * HW;
  localparam logic [AW-1:0] A_CFG   = AW'(0);
  localparam logic [AW-1:0] A_MODEA = AW'(1);
  localparam logic [AW-1:0] A_MODEB = AW'(2);
  localparam logic [AW-1:0] A_CTRL  = AW'(3);
  localparam logic [AW-1:0] A_MASK  = AW'(4);
  localparam logic [AW-1:0] A_RAW   = AW'(5);
  localparam logic [AW-1:0] A_MST   = AW'(6);
  localparam logic [AW-1:0] A_CLR   = AW'(7);
  localparam logic [AW-1:0] A_LDA   = AW'(8);
  localparam logic [AW-1:0] A_LDB   = AW'(9);
  localparam logic [AW-1:0] A_MTA   = AW'(10);
  localparam logic [AW-1:0] A_MTB   = AW'(11);
  localparam logic [AW-1:0] A_PRA   = AW'(12);
  localparam logic [AW-1:0] A_PRB   = AW'(13);
  localparam logic [AW-1:0] A_CNT   = AW'(14);

  logic [2:0]    cfg_q;
  logic [3:0]    mode_a_q, mode_b_q;
  logic [15:0]   ctrl_q;
  logic [7:0]    imask_q, raw_q, pre_a_q, pre_b_q;
  logic [HW-1:0] ld_a_q, ld_b_q, mt_a_q, mt_b_q;
  logic [DW-1:0] cnt_q;
  logic          run_a;

  wire wide      = (cfg_q < 3'd4);
  wire ctrl_wr   = wr_en && (addr == A_CTRL);
  wire ctrl_rise = ctrl_wr && wdata[0] && !ctrl_q[0];
  wire ctrl_fall = ctrl_wr && !wdata[0] && ctrl_q[0];
  wire cd_step   = run_a && (cfg_q == 3'd0) && tick_en;
  wire timeout_a = cd_step && (cnt_q == DW'(1));
  wire rtc_step  = run_a && (cfg_q == 3'd1) && sec_tick;
  wire [DW-1:0] reload   = {ld_b_q, ld_a_q};
  wire [DW-1:0] rtc_next = cnt_q + DW'(1);
  wire rtc_hit   = rtc_step && (rtc_next == {mt_b_q, mt_a_q});
  wire [7:0] clr_bits = (wr_en && addr == A_CLR) ? wdata[7:0] : 8'h00;

  assign irq = |(raw_q & imask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0; mode_a_q <= '0; mode_b_q <= '0; ctrl_q <= '0;
      imask_q <= '0; pre_a_q <= '0; pre_b_q <= '0;
      ld_a_q <= '0; ld_b_q <= '0; mt_a_q <= '0; mt_b_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CFG:   cfg_q    <= wdata[2:0];
        A_MODEA: mode_a_q <= wdata[3:0];
        A_MODEB: mode_b_q <= wdata[3:0];
        A_CTRL:  ctrl_q   <= wdata[15:0];
        A_MASK:  imask_q  <= wdata[7:0] & 8'h77;
        A_LDA: begin
          ld_a_q <= wdata[HW-1:0];
          if (wide) ld_b_q <= wdata[DW-1:HW];
        end
        A_LDB:   ld_b_q <= wdata[HW-1:0];
        A_MTA: begin
          mt_a_q <= wdata[HW-1:0];
          if (wide) mt_b_q <= wdata[DW-1:HW];
        end
        A_MTB:   mt_b_q  <= wdata[HW-1:0];
        A_PRA:   pre_a_q <= wdata[7:0];
        A_PRB:   pre_b_q <= wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_a <= 1'b0;
    end else if (ctrl_rise) begin
      run_a <= 1'b1;
      cnt_q <= (cfg_q == 3'd0) ? reload : '0;
    end else if (ctrl_fall) begin
      run_a <= 1'b0;
    end else if (cd_step) begin
      if (timeout_a) begin
        cnt_q <= mode_a_q[0] ? '0 : reload;
        run_a <= !mode_a_q[0];
      end else begin
        cnt_q <= cnt_q - DW'(1);
      end
    end else if (rtc_step) begin
      cnt_q <= rtc_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      trig  <= 1'b0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | {4'b0, rtc_hit, 2'b0, timeout_a};
      trig  <= timeout_a && ctrl_q[5];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CFG:   rdata = DW'(cfg_q);
      A_MODEA: rdata = DW'(mode_a_q);
      A_MODEB: rdata = DW'(mode_b_q);
      A_CTRL:  rdata = DW'(ctrl_q);
      A_MASK:  rdata = DW'(imask_q);
      A_RAW:   rdata = DW'(raw_q);
      A_MST:   rdata = DW'(raw_q & imask_q);
      A_LDA:   rdata = {wide ? ld_b_q : '0, ld_a_q};
      A_LDB:   rdata = DW'(ld_b_q);
      A_MTA:   rdata = {wide ? mt_b_q : '0, mt_a_q};
      A_MTB:   rdata = DW'(mt_b_q);
      A_PRA:   rdata = DW'(pre_a_q);
      A_PRB:   rdata = DW'(pre_b_q);
      A_CNT:   rdata = cnt_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_half_timer_checker.sv
module dual_half_timer_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          sec_tick,
  input logic          trig,
  input logic [2:0]    cfg_q,
  input logic [15:0]   ctrl_q,
  input logic [DW-1:0] cnt_q,
  input logic          run_a,
  input logic          timeout_a,
  input logic          mode_a0
);
  AST_TRIG_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> ($past(timeout_a) && $past(ctrl_q[5]))); // R5
  AST_TRIG_COUNTDOWN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> ($past(cfg_q) == 3'd0)); // R5
  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_a && mode_a0 && !wr_en) |=> !run_a); // R4
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_a && !wr_en) |=> $stable(cnt_q)); // R11
  AST_RTC_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_a && cfg_q == 3'd1 && !sec_tick && !wr_en) |=> $stable(cnt_q)); // R9
endmodule

bind dual_half_timer dual_half_timer_checker #(.DW(2*HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sec_tick(sec_tick), .trig(trig),
  .cfg_q(cfg_q), .ctrl_q(ctrl_q), .cnt_q(cnt_q), .run_a(run_a),
  .timeout_a(timeout_a), .mode_a0(mode_a_q[0])
);

// File: tb/tb_dual_half_timer.sv
`timescale 1ns/1ps
module tb_dual_half_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick_en = 1'b0;
  logic        sec_tick = 1'b0;
  logic        irq, trig;

  int checks = 0, fails = 0, cyc = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_half_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_en(tick_en), .sec_tick(sec_tick),
    .irq(irq), .trig(trig));

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // monitor: every trig pulse is matched against the next expected cycle
  always @(negedge clk) begin
    if (rst_n && trig) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5: actual trig at cycle %0d expected none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          fails++;
          $display("FAIL R5: actual trig cycle %0d expected %0d", cyc, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, output int stamp);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    stamp = cyc;
  endtask

  task automatic wrq(input logic [3:0] a, input logic [31:0] d);
    int s;
    wr(a, d, s);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic expect_trig(int c);
    exp_q.push_back(c);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sec_pulse();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int c, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 15; a++) begin
      rd(4'(a), v); chk("R1", v, 32'h0);
    end
    chk("R1", {30'b0, irq, trig}, 32'h0);

    // R8 wide writes in configuration 0
    wrq(4'd8, 32'h0001_0002);
    rd(4'd8, v); chk("R8", v, 32'h0001_0002);
    rd(4'd9, v); chk("R8", v, 32'h0000_0001);
    wrq(4'd10, 32'h0007_0003);
    rd(4'd10, v); chk("R8", v, 32'h0007_0003);
    rd(4'd11, v); chk("R8", v, 32'h0000_0007);

    // R2 joined reload visible with tick_en low
    wrq(4'd3, 32'h1);
    rd(4'd14, v); chk("R2", v, 32'h0001_0002);
    wrq(4'd3, 32'h0);

    // R10 prescale storage
    wrq(4'd12, 32'h1FF);
    wrq(4'd13, 32'h2AB);
    rd(4'd12, v); chk("R10", v, 32'hFF);
    rd(4'd13, v); chk("R10", v, 32'hAB);

    // R3 periodic with trigger; prescale 0xFF must not stretch it (R10)
    wrq(4'd8, 32'd5);
    @(negedge clk); tick_en = 1'b1;
    wr(4'd3, 32'h21, c);
    expect_trig(c + 5); expect_trig(c + 10); expect_trig(c + 15);
    while (cyc < c + 16) @(negedge clk);
    wr(4'd3, 32'h20, d);
    rd(4'd14, v); chk("R11", v, 32'(5 - (d - c - 16)));
    rd(4'd5, v); chk("R3", v, 32'h1);
    idle(10);
    rd(4'd14, v); chk("R11", v, 32'(5 - (d - c - 16)));
    chk("R5", exp_q.size(), 0);

    // R6 mask and irq
    wrq(4'd4, 32'hFF);
    rd(4'd4, v); chk("R6", v, 32'h77);
    rd(4'd6, v); chk("R6", v, 32'h1);
    chk("R6", {31'b0, irq}, 32'h1);
    // R7 clear
    wrq(4'd7, 32'h1);
    rd(4'd5, v); chk("R7", v, 32'h0);
    chk("R7", {31'b0, irq}, 32'h0);

    // R4 one-shot
    wrq(4'd1, 32'h1);
    wrq(4'd8, 32'd4);
    wrq(4'd3, 32'h0);
    wr(4'd3, 32'h21, c);
    expect_trig(c + 4);
    idle(12);
    rd(4'd14, v); chk("R4", v, 32'h0);
    rd(4'd5, v); chk("R4", v, 32'h1);
    chk("R4", exp_q.size(), 0);
    wrq(4'd7, 32'hFF);
    wrq(4'd3, 32'h0);

    // R5 no trigger with control bit 5 clear
    wrq(4'd1, 32'h0);
    wrq(4'd8, 32'd3);
    wrq(4'd3, 32'h1);
    idle(8);
    wrq(4'd3, 32'h0);
    rd(4'd5, v); chk("R5", v, 32'h1);
    wrq(4'd7, 32'hFF);
    @(negedge clk); tick_en = 1'b0;

    // R8 narrow rule at configuration 4
    wrq(4'd0, 32'h4);
    wrq(4'd9, 32'h11);
    wrq(4'd8, 32'hABCD_1234);
    rd(4'd8, v); chk("R8", v, 32'h0000_1234);
    rd(4'd9, v); chk("R8", v, 32'h0000_0011);
    wrq(4'd10, 32'h5555_0003);
    rd(4'd10, v); chk("R8", v, 32'h0000_0003);
    rd(4'd11, v); chk("R8", v, 32'h0000_0007);

    // R9 seconds counter with match 3
    wrq(4'd0, 32'h1);
    wrq(4'd11, 32'h0);
    wrq(4'd3, 32'h1);
    rd(4'd14, v); chk("R9", v, 32'h0);
    sec_pulse(); sec_pulse();
    idle(4);
    rd(4'd14, v); chk("R9", v, 32'h2);
    rd(4'd5, v); chk("R9", v, 32'h0);
    sec_pulse();
    rd(4'd14, v); chk("R9", v, 32'h3);
    rd(4'd5, v); chk("R9", v, 32'h8);
    chk("R6", {31'b0, irq}, 32'h0);
    sec_pulse();
    rd(4'd14, v); chk("R9", v, 32'h4);
    wrq(4'd7, 32'h8);
    rd(4'd5, v); chk("R7", v, 32'h0);

    idle(3);
    chk("R5", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule